// File: doc/BRIEF.md
# Way-Locking LRU Replacement Selector

This block tracks the age ordering of the four ways of every entry in a 4-way set-associative cache and names the way to evict on a fill. Each entry keeps a 6-bit field. Each bit of the field compares the ages of one pair of ways, so the whole field is a complete pairwise age ordering. When an access strobe arrives, the field of the addressed entry is rewritten at the next clock edge so that the accessed way becomes the newest. The relative order of the other three ways is kept.

Two lock inputs can remove way 2 and way 3 from replacement. The victim is then the oldest way among those still allowed. The locks affect only the victim choice. An access to a locked way still refreshes its age. The victim decode and the next-field logic are combinational, and both act on the currently stored field of the addressed entry. A small registered array holds one field per entry.

Top module: `lru_lock_sel`

## Requirements
- R1: While reset is asserted, and after it is released, every entry's field is 000000.
- R2: Field bit meaning, with 1 meaning the lower-numbered way of the pair is older: bit 5 covers ways (0,1), bit 4 covers (0,2), bit 3 covers (0,3), bit 2 covers (1,2), bit 1 covers (1,3) and bit 0 covers (2,3). `lru_cur` shows the stored field of the entry selected by `acc_idx`.
- R3: `lru_upd` is the field with `acc_way` made the newest and the order of the other ways unchanged. Way 0 clears bits 5..3. Way 1 sets bit 5 and clears bits 2..1. Way 2 sets bits 4 and 2 and clears bit 0. Way 3 sets bits 3, 1 and 0. When `acc_valid` is high, this value is stored into the selected entry at the rising edge, and the other entries do not change.
- R4: With `acc_valid` low, no entry changes, whatever `acc_way` and `acc_idx` carry.
- R5: With neither lock set, `victim` is the way older than all three others. Code 000000 gives way 3, and any code 111xxx gives way 0.
- R6: With only `lock_w3` set, `victim` is the oldest of ways 0, 1 and 2. For example, 000000 gives 2, 011111 gives 1 and 110000 gives 0.
- R7: With both locks set, `victim` is way 1 when bit 5 is 0 and way 0 when bit 5 is 1.
- R8: With only `lock_w2` set, `victim` is the oldest of ways 0, 1 and 3.
- R9: An access to a locked way updates the field exactly as in R3.
- R10: `victim` is decoded from the field stored before the edge. In the cycle of an access it reflects the pre-update ordering, and the update becomes visible one edge later.
- R11: Every stored field is one of the 24 legal codes, meaning a consistent total order of the four ways.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_idx | input | IDX_W | Entry being accessed or filled |
| acc_valid | input | 1 | Access strobe; updates the entry at the next edge |
| acc_way | input | 2 | Way that was hit or filled |
| lock_w2 | input | 1 | Exclude way 2 from replacement |
| lock_w3 | input | 1 | Exclude way 3 from replacement |
| lru_cur | output | 6 | Stored field of the selected entry |
| lru_upd | output | 6 | Field after an access to `acc_way` |
| victim | output | 2 | Way to replace in the selected entry |

## Verification
The victim decode and the age update can hit the same entry in the same cycle. A fill strobe reads `victim` from the entry while that entry's field is being rewritten. The bench provokes this on nearly every cycle by strobing random ways into a small array of entries. It sweeps all four lock combinations inside the cycle before the edge, so `victim` is judged against the pre-update order. The new order is judged on `lru_cur` one edge later. The expected values come from a per-entry rank model that is independent of the bit encoding, so every reachable code is compared under every lock setting.

// File: rtl/lru_lock_sel.sv
module lru_lock_sel #(
  parameter int ENTRIES = 16,
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] acc_idx,
  input  logic             acc_valid,
  input  logic [1:0]       acc_way,
  input  logic             lock_w2,
  input  logic             lock_w3,
  output logic [5:0]       lru_cur,
  output logic [5:0]       lru_upd,
  output logic [1:0]       victim
);

  logic [5:0] mem [ENTRIES];
  logic [3:0][3:0] older;
  logic [3:0] allowed;
  logic [3:0] beats;

  assign lru_cur = mem[acc_idx];
  assign allowed = {~lock_w3, ~lock_w2, 2'b11};

  always_comb begin
    lru_upd = lru_cur;
    case (acc_way)
      2'd0: lru_upd[5:3] = 3'b000;
      2'd1: begin lru_upd[5] = 1'b1; lru_upd[2:1] = 2'b00; end
      2'd2: begin lru_upd[4] = 1'b1; lru_upd[2] = 1'b1; lru_upd[0] = 1'b0; end
      default: begin lru_upd[3] = 1'b1; lru_upd[1] = 1'b1; lru_upd[0] = 1'b1; end
    endcase
  end

  always_comb begin
    older = '0;
    older[0][1] = lru_cur[5];  older[1][0] = ~lru_cur[5];
    older[0][2] = lru_cur[4];  older[2][0] = ~lru_cur[4];
    older[0][3] = lru_cur[3];  older[3][0] = ~lru_cur[3];
    older[1][2] = lru_cur[2];  older[2][1] = ~lru_cur[2];
    older[1][3] = lru_cur[1];  older[3][1] = ~lru_cur[1];
    older[2][3] = lru_cur[0];  older[3][2] = ~lru_cur[0];
  end

  for (genvar w = 0; w < 4; w++) begin : g_beat
    always_comb begin
      beats[w] = allowed[w];
      for (int v = 0; v < 4; v++)
        if (v != w && allowed[v] && !older[w][v]) beats[w] = 1'b0;
    end
  end

  always_comb begin
    if (beats[0])      victim = 2'd0;
    else if (beats[1]) victim = 2'd1;
    else if (beats[2]) victim = 2'd2;
    else if (beats[3]) victim = 2'd3;
    else               victim = 2'd0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int e = 0; e < ENTRIES; e++) mem[e] <= 6'b000000;
    end else if (acc_valid) begin
      mem[acc_idx] <= lru_upd;
    end
  end

  function automatic logic code_legal(input logic [5:0] c);
    logic [3:0][1:0] sc;
    sc[0] = 2'(c[5] + c[4] + c[3]);
    sc[1] = 2'(!c[5] + c[2] + c[1]);
    sc[2] = 2'(!c[4] + !c[2] + c[0]);
    sc[3] = 2'(!c[3] + !c[1] + !c[0]);
    code_legal = (sc[0] != sc[1]) && (sc[0] != sc[2]) && (sc[0] != sc[3]) &&
                 (sc[1] != sc[2]) && (sc[1] != sc[3]) && (sc[2] != sc[3]) &&
                 ((c[5] + c[4] + c[3]) != 3'd0 || sc[0] == 2'd0);
  endfunction

  AST_FIELD_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    code_legal(lru_cur)); // R11
  AST_LOCK3_SAFE: assert property (@(posedge clk) disable iff (!rst_n)
    lock_w3 |-> victim != 2'd3); // R6
  AST_LOCK23_SAFE: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_w2 && lock_w3) |-> victim[1] == 1'b0); // R7
  AST_WAY0_NEWEST: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_way == 2'd0) |=> mem[$past(acc_idx)][5:3] == 3'b000); // R3
  AST_WAY3_NEWEST: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_way == 2'd3) |=> {mem[$past(acc_idx)][3], mem[$past(acc_idx)][1:0]} == 3'b111); // R9
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_valid |=> mem[$past(acc_idx)] == $past(lru_cur)); // R4

endmodule

// File: tb/lru_lock_sel_bench.sv
`timescale 1ns/10ps
module lru_lock_sel_bench;
  localparam int ENT = 4;
  localparam int IW = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [IW-1:0] acc_idx = '0;
  logic acc_valid = 1'b0;
  logic [1:0] acc_way = '0;
  logic lock_w2 = 1'b0, lock_w3 = 1'b0;
  logic [5:0] lru_cur, lru_upd;
  logic [1:0] victim;

  int n_run = 0, n_fail = 0;
  bit done = 0;
  int rank [ENT][4];

  always #2 clk = ~clk;

  lru_lock_sel #(.ENTRIES(ENT)) u_lru_lock_sel (
    .clk(clk), .rst_n(rst_n), .acc_idx(acc_idx), .acc_valid(acc_valid),
    .acc_way(acc_way), .lock_w2(lock_w2), .lock_w3(lock_w3),
    .lru_cur(lru_cur), .lru_upd(lru_upd), .victim(victim));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [5:0] code_of(input int r[4]);
    code_of = {r[0] > r[1], r[0] > r[2], r[0] > r[3], r[1] > r[2], r[1] > r[3], r[2] > r[3]};
  endfunction

  function automatic void touch(inout int r[4], input int w);
    int old = r[w];
    for (int k = 0; k < 4; k++) if (r[k] < old) r[k]++;
    r[w] = 0;
  endfunction

  function automatic int oldest(input int r[4], input bit l2, input bit l3);
    int best = -1, bw = 0;
    for (int k = 0; k < 4; k++) begin
      if ((k == 2 && l2) || (k == 3 && l3)) continue;
      if (r[k] > best) begin best = r[k]; bw = k; end
    end
    return bw;
  endfunction

  task automatic check_victims(input int r[4], input string tag);
    for (int lk = 0; lk < 4; lk++) begin
      lock_w2 = lk[0]; lock_w3 = lk[1];
      #0.1;
      chk(victim == 2'(oldest(r, lk[0], lk[1])),
          lk == 0 ? {"R5 ", tag} : lk == 2 ? {"R6 ", tag} : lk == 3 ? {"R7 ", tag} : {"R8 ", tag},
          victim, oldest(r, lk[0], lk[1]));
    end
  endtask

  initial begin
    #(4.0 * 200000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    string ptag;
    int r[4];
    for (int e = 0; e < ENT; e++) for (int k = 0; k < 4; k++) rank[e][k] = k;
    ptag = "R2";
    #5;
    for (int e = 0; e < ENT; e++) begin
      acc_idx = IW'(e); #0.2;
      chk(lru_cur == 6'b000000, "R1 in reset", lru_cur, 0);
    end
    @(negedge clk); rst_n = 1'b1;
    for (int e = 0; e < ENT; e++) begin
      acc_idx = IW'(e); #0.1;
      chk(lru_cur == 6'b000000, "R1 after reset", lru_cur, 0);
      r = rank[e];
      check_victims(r, "reset code");
    end
    for (int it = 0; it < 4000; it++) begin
      int e, w;
      bit v;
      logic [5:0] exp_upd;
      @(negedge clk);
      e = $urandom_range(ENT - 1);
      w = $urandom_range(3);
      v = ($urandom_range(9) != 0);
      acc_idx = IW'(e); acc_way = 2'(w); acc_valid = v;
      #0.2;
      r = rank[e];
      chk(lru_cur == code_of(r), {ptag, " stored field"}, lru_cur, code_of(r));
      touch(r, w);
      exp_upd = code_of(r);
      chk(lru_upd == exp_upd, w >= 2 ? "R3 R9 next field" : "R3 next field", lru_upd, exp_upd);
      r = rank[e];
      check_victims(r, v ? "R10 pre-update" : "idle");
      lock_w2 = $urandom_range(1); lock_w3 = $urandom_range(1);
      @(posedge clk);
      if (v) touch(rank[e], w);
      if (!v) ptag = "R4 idle hold";
      else if ((w == 2 && lock_w2) || (w == 3 && lock_w3)) ptag = "R9 locked hit";
      else ptag = "R3 R11 after access";
    end
    @(negedge clk);
    acc_valid = 1'b0;
    for (int e = 0; e < ENT; e++) begin
      acc_idx = IW'(e); #0.1;
      r = rank[e];
      chk(lru_cur == code_of(r), "R11 final field", lru_cur, code_of(r));
    end
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule